// File: doc/BRIEF.md
# Streaming Combinator Rewriter

This block makes one rewriting pass over a byte stream of concatenative combinator code. Operators are single lowercase letters. They are written in postfix style: each operator comes before the bracketed blocks it consumes. The block holds a small operand buffer. When an operator arrives, the block captures the operator's blocks into that buffer. If every operand closes inside the buffer, the block writes out the rewritten text. If an operand is too large, malformed or missing, the block writes the original text back out, so that a later pass can try again. No fault is ever raised.

Composition is handled opportunistically. When the first operand is too large to hold, its text is streamed out as it arrives. At its closing bracket the block looks at the next byte. If that byte is an opening bracket, the `][` pair is dropped and the two blocks merge. If it is anything else, the closing bracket is replaced by the open-block marker `\`. The text `[A\` means the same as a pending composition of `[A]`.

Both stream sides use valid/ready. A byte moves only in a cycle where valid and ready are both high. Pass-through bytes travel combinationally from input to output, so the input ready of a pass-through byte follows the output ready. While output is stalled, no byte is lost, duplicated or reordered, and the offered output byte stays unchanged. The stream ends with a zero byte. The zero byte is forwarded, and after its transfer `done` stays high until reset.

Top module: `streaming_rewriter`

## Requirements
- R1: An output byte transfers only when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The output sequence does not depend on the back-pressure pattern.
- R2: Bytes other than the six operator letters (0x61 a, 0x62 b, 0x63 c, 0x64 d, 0x69 i, 0x6F o) and the zero byte are passed through unchanged when they do not follow an operator. This includes `[` 0x5B, `]` 0x5D and `\` 0x5C.
- R3: Apply: `a[A][B]` becomes `[B]A`.
- R4: Bind: `b[A][B]` becomes `[A[B]]`.
- R5: Copy: `c[X]` becomes `[X][X]` when X is at most DEPTH-2 bytes long. At DEPTH-1 bytes or more, the text is copied unchanged.
- R6: Drop: `d[X]` produces nothing.
- R7: Inline: `i[A]` becomes `A`. The result is not rewritten again in the same pass.
- R8: Compose: `o[A][B]` becomes `[AB]` when both blocks fit in the buffer.
- R9: Compose still becomes `[AB]` when A or B overflows the buffer. The overflowing text streams through, and the `][` separator is removed.
- R10: Compose with no second block becomes `[A\`, whatever the size of A.
- R11: An operator that cannot be reduced is copied unchanged together with the captured text. This covers an operator not followed by `[`, a missing second block, an overflow for an operator other than compose, and a stream that ends inside an operand.
- R12: The buffer holds DEPTH raw bytes, brackets included, where DEPTH is 32 by default. A rule fires only if every operand closes within those DEPTH bytes. An operand closed by `\` instead of `]` is copied unchanged.
- R13: The zero byte is forwarded. After its transfer, `done` stays high and `in_ready` and `out_valid` stay low until reset.
- R14: Nested brackets are counted. A block ends only when its nesting depth returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block accepts the offered byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| done | output | 1 | End-of-stream byte has been emitted |

## Verification
The output hold property assumes that the upstream side keeps `in_valid` and `in_data` steady until a byte is taken. This matters because a pass-through byte is offered straight from the input. The bench drives each byte at the falling edge and changes it only after it has seen `in_ready` high. The stimulus uses `x` and `y` as operand fillers, so no operator letter appears inside an operand. Operand lengths are swept across both sides of the buffer limit, and the expected text is computed from those lengths. Random output stalls are applied on alternate runs.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam logic [7:0] CH_OPEN  = 8'h5B;
  localparam logic [7:0] CH_CLOSE = 8'h5D;
  localparam logic [7:0] CH_MARK  = 8'h5C;
  localparam logic [7:0] CH_EOS   = 8'h00;
  localparam logic [7:0] OP_APPLY = 8'h61;
  localparam logic [7:0] OP_BIND  = 8'h62;
  localparam logic [7:0] OP_COPY  = 8'h63;
  localparam logic [7:0] OP_DROP  = 8'h64;
  localparam logic [7:0] OP_INL   = 8'h69;
  localparam logic [7:0] OP_COMP  = 8'h6F;

  typedef enum logic [2:0] {
    ST_SCAN, ST_OPEN, ST_BODY, ST_EMIT, ST_COMP, ST_JOIN, ST_DONE
  } rw_state_t;

  // What the emitter writes once capture stops
  typedef enum logic [2:0] {
    PK_RULE, PK_VERB, PK_CMPA, PK_CMPB, PK_CMPO
  } plan_t;

  function automatic logic is_op(input logic [7:0] b);
    return (b == OP_APPLY) || (b == OP_BIND) || (b == OP_COPY) ||
           (b == OP_DROP) || (b == OP_INL) || (b == OP_COMP);
  endfunction

  function automatic logic two_operands(input logic [7:0] b);
    return (b == OP_APPLY) || (b == OP_BIND) || (b == OP_COMP);
  endfunction
endpackage

// File: rtl/rw_opbuf.sv
module rw_opbuf #(
  parameter int DEPTH = 32,
  parameter int IW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr < LIMIT)) mem[waddr[AW-1:0]] <= wdata;
  end

  always_comb rdata = (raddr < LIMIT) ? mem[raddr[AW-1:0]] : 8'h00;

  // R12: the controller never writes past the buffer
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr < LIMIT);
endmodule

// File: rtl/rw_plan.sv
module rw_plan
  import rw_pkg::*;
#(
  parameter int IW = 7,
  parameter int NP = 4
) (
  input  plan_t                 kind,
  input  logic [7:0]            op,
  input  logic [IW-1:0]         cnt,
  input  logic [IW-1:0]         ea,
  input  logic [IW-1:0]         eb,
  output logic [NP-1:0]         p_use,
  output logic [NP-1:0]         p_lit,
  output logic [NP-1:0][7:0]    p_chr,
  output logic [NP-1:0][IW-1:0] p_lo,
  output logic [NP-1:0][IW-1:0] p_hi
);
  localparam logic [IW-1:0] ONE = IW'(1);
  localparam logic [IW-1:0] TWO = IW'(2);

  // Ranges are [lo, hi) in buffer index order
  always_comb begin
    p_use = '0;
    p_lit = '0;
    p_chr = '0;
    p_lo  = '0;
    p_hi  = '0;
    unique case (kind)
      PK_RULE: begin
        unique case (op)
          OP_APPLY: begin
            p_use[0] = 1'b1; p_lo[0] = ea + ONE; p_hi[0] = eb + ONE;
            p_use[1] = 1'b1; p_lo[1] = ONE;      p_hi[1] = ea;
          end
          OP_BIND: begin
            p_use[0] = 1'b1; p_lo[0] = '0;       p_hi[0] = ea;
            p_use[1] = 1'b1; p_lo[1] = ea + ONE; p_hi[1] = eb + ONE;
            p_use[2] = 1'b1; p_lit[2] = 1'b1;    p_chr[2] = CH_CLOSE;
          end
          OP_COPY: begin
            p_use[0] = 1'b1; p_lo[0] = '0; p_hi[0] = ea + ONE;
            p_use[1] = 1'b1; p_lo[1] = '0; p_hi[1] = ea + ONE;
          end
          OP_INL: begin
            p_use[0] = 1'b1; p_lo[0] = ONE; p_hi[0] = ea;
          end
          OP_COMP: begin
            p_use[0] = 1'b1; p_lo[0] = '0;       p_hi[0] = ea;
            p_use[1] = 1'b1; p_lo[1] = ea + TWO; p_hi[1] = eb + ONE;
          end
          default: ;  // drop emits nothing
        endcase
      end
      PK_VERB: begin
        p_use[0] = 1'b1; p_lit[0] = 1'b1; p_chr[0] = op;
        p_use[1] = 1'b1; p_lo[1] = '0;    p_hi[1] = cnt;
      end
      PK_CMPA: begin
        p_use[0] = 1'b1; p_lo[0] = '0; p_hi[0] = cnt;
      end
      PK_CMPB: begin
        p_use[0] = 1'b1; p_lo[0] = '0;       p_hi[0] = ea;
        p_use[1] = 1'b1; p_lo[1] = ea + TWO; p_hi[1] = cnt;
      end
      default: begin  // PK_CMPO
        p_use[0] = 1'b1; p_lo[0] = '0;    p_hi[0] = ea;
        p_use[1] = 1'b1; p_lit[1] = 1'b1; p_chr[1] = CH_MARK;
      end
    endcase
  end
endmodule

// File: rtl/streaming_rewriter.sv
module streaming_rewriter
  import rw_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NEST_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       done
);
  localparam int IW = $clog2(DEPTH + 1) + 1;
  localparam int NP = 4;
  localparam int SW = $clog2(NP);
  localparam int PW = SW + 1;
  localparam logic [IW-1:0]     FULL  = IW'(DEPTH);
  localparam logic [IW-1:0]     ONE   = IW'(1);
  localparam logic [NEST_W-1:0] NONE1 = NEST_W'(1);
  localparam logic [PW-1:0]     PEND  = PW'(NP);

  rw_state_t st, st_n;
  plan_t kind, kind_n;
  logic [7:0] op, op_n;
  logic [IW-1:0] cnt, cnt_n, ea, ea_n, eb, eb_n, pos, pos_n;
  logic [NEST_W-1:0] depth, dep_n;
  logic blk, blk_n, pos_ok, pok_n;
  logic [PW-1:0] pi, pi_n;

  logic we;
  logic [7:0] rdata;
  logic [NP-1:0] p_use, p_lit;
  logic [NP-1:0][7:0] p_chr;
  logic [NP-1:0][IW-1:0] p_lo, p_hi;
  logic [SW-1:0] sel;

  rw_opbuf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(cnt), .wdata(in_data),
    .raddr(pos), .rdata(rdata)
  );

  rw_plan #(.IW(IW), .NP(NP)) u_plan (
    .kind(kind), .op(op), .cnt(cnt), .ea(ea), .eb(eb),
    .p_use(p_use), .p_lit(p_lit), .p_chr(p_chr), .p_lo(p_lo), .p_hi(p_hi)
  );

  logic is_open, is_close, is_mark, is_eos, full;
  assign is_open  = (in_data == CH_OPEN);
  assign is_close = (in_data == CH_CLOSE);
  assign is_mark  = (in_data == CH_MARK);
  assign is_eos   = (in_data == CH_EOS);
  assign full     = (cnt == FULL);
  assign sel      = pi[SW-1:0];
  assign done     = (st == ST_DONE);

  always_comb begin
    st_n = st; kind_n = kind; op_n = op; cnt_n = cnt; ea_n = ea; eb_n = eb;
    dep_n = depth; blk_n = blk; pi_n = pi; pos_n = pos; pok_n = pos_ok;
    in_ready = 1'b0; out_valid = 1'b0; out_data = in_data; we = 1'b0;
    unique case (st)
      ST_SCAN: begin
        in_ready  = is_op(in_data) ? 1'b1 : out_ready;
        out_valid = in_valid && !is_op(in_data);
        if (in_valid) begin
          if (is_op(in_data)) begin
            op_n = in_data; cnt_n = '0; blk_n = 1'b0; st_n = ST_OPEN;
          end else if (out_ready && is_eos) begin
            st_n = ST_DONE;
          end
        end
      end
      ST_OPEN: if (in_valid) begin
        st_n = ST_EMIT; pi_n = '0; pok_n = 1'b0;
        if (is_open && !full) begin
          in_ready = 1'b1; we = 1'b1; cnt_n = cnt + ONE; dep_n = NONE1; st_n = ST_BODY;
        end else if (is_open && blk && op == OP_COMP) begin
          in_ready = 1'b1; kind_n = PK_CMPB;   // drop the separator, B streams on
        end else if (blk && op == OP_COMP) begin
          kind_n = PK_CMPO;
        end else begin
          kind_n = PK_VERB;
        end
      end
      ST_BODY: if (in_valid) begin
        if (is_eos || full) begin
          st_n = ST_EMIT; pi_n = '0; pok_n = 1'b0;
          if (is_eos || op != OP_COMP) kind_n = PK_VERB;
          else kind_n = blk ? PK_CMPB : PK_CMPA;
        end else begin
          in_ready = 1'b1; we = 1'b1; cnt_n = cnt + ONE;
          if (is_open) dep_n = depth + NONE1;
          else if (is_close || is_mark) begin
            dep_n = depth - NONE1;
            if (depth == NONE1) begin
              if (is_mark) begin
                kind_n = PK_VERB; st_n = ST_EMIT; pi_n = '0; pok_n = 1'b0;
              end else if (!blk && two_operands(op)) begin
                ea_n = cnt; blk_n = 1'b1; st_n = ST_OPEN;
              end else begin
                if (!blk) ea_n = cnt;
                eb_n = cnt; kind_n = PK_RULE;
                st_n = ST_EMIT; pi_n = '0; pok_n = 1'b0;
              end
            end
          end
        end
      end
      ST_EMIT: begin
        if (pi == PEND) begin
          st_n = (kind == PK_CMPA) ? ST_COMP : ST_SCAN;
        end else if (!p_use[sel]) begin
          pi_n = pi + PW'(1); pok_n = 1'b0;
        end else if (!pos_ok) begin
          pos_n = p_lo[sel]; pok_n = 1'b1;
        end else if (p_lit[sel]) begin
          out_valid = 1'b1; out_data = p_chr[sel];
          if (out_ready) begin pi_n = pi + PW'(1); pok_n = 1'b0; end
        end else if (pos >= p_hi[sel]) begin
          pi_n = pi + PW'(1); pok_n = 1'b0;
        end else begin
          out_valid = 1'b1; out_data = rdata;
          if (out_ready) pos_n = pos + ONE;
        end
      end
      ST_COMP: if (in_valid) begin
        if (is_close && depth == NONE1) begin
          in_ready = 1'b1; dep_n = '0; st_n = ST_JOIN;
        end else begin
          out_valid = 1'b1; in_ready = out_ready;
          if (out_ready) begin
            if (is_eos) st_n = ST_DONE;
            else if (is_open) dep_n = depth + NONE1;
            else if (is_close || is_mark) begin
              dep_n = depth - NONE1;
              if (depth == NONE1) st_n = ST_SCAN;
            end
          end
        end
      end
      ST_JOIN: if (in_valid) begin
        if (is_open) begin
          in_ready = 1'b1; st_n = ST_SCAN;
        end else begin
          out_valid = 1'b1; out_data = CH_MARK;
          if (out_ready) st_n = ST_SCAN;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_SCAN; kind <= PK_VERB; op <= '0; cnt <= '0; ea <= '0; eb <= '0;
      depth <= '0; blk <= 1'b0; pi <= '0; pos <= '0; pos_ok <= 1'b0;
    end else begin
      st <= st_n; kind <= kind_n; op <= op_n; cnt <= cnt_n; ea <= ea_n; eb <= eb_n;
      depth <= dep_n; blk <= blk_n; pi <= pi_n; pos <= pos_n; pos_ok <= pok_n;
    end
  end

  // R1: a stalled output byte is held
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R13: end of stream is terminal
  assert_done_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !in_ready && !out_valid);
  // R14: while capturing, the operand is open and non-empty
  assert_nest_open_R14: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BODY |-> depth != '0 && cnt != '0);
  // R9: streamed first operand is still open
  assert_comp_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_COMP |-> depth != '0);
endmodule

// File: tb/tb_streaming_rewriter.sv
module tb_streaming_rewriter;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 2;
  localparam int DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, done;
  logic [7:0] in_data = 8'h00, out_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  streaming_rewriter #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  function automatic string rep(input string ch, input int n);
    string s = "";
    for (int k = 0; k < n; k++) s = {s, ch};
    return s;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_stream(input string s, output bit ok);
    int n;
    logic [7:0] b;
    bit acc;
    int tries;
    n = s.len(); ok = 1'b1;
    for (int i = 0; i <= n; i++) begin
      b = (i == n) ? 8'h00 : s[i];
      acc = 1'b0; tries = 0;
      while (!acc && tries < 4000) begin
        @(negedge clk); in_valid = 1'b1; in_data = b; #(Q);
        acc = in_ready; tries++;
      end
      if (!acc) begin ok = 1'b0; break; end
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic collect(input bit bp, input logic [7:0] seed, output string got, output bit ok);
    logic [7:0] lf;
    lf = seed; got = ""; ok = 1'b0;
    for (int t = 0; t < 8000; t++) begin
      @(negedge clk);
      out_ready = bp ? lf[0] : 1'b1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      #(Q);
      if (out_valid && out_ready) begin
        if (out_data == 8'h00) begin ok = 1'b1; break; end
        got = {got, $sformatf("%c", out_data)};
      end
    end
  endtask

  task automatic run_test(input string inp, input string exp, input string req, input bit bp);
    string got;
    bit dok, cok;
    do_reset();
    fork
      drive_stream(inp, dok);
      collect(bp, 8'hA5 ^ 8'(inp.len()), got, cok);
    join
    out_ready = 1'b1;
    checks++;
    if (!dok || !cok || got != exp) begin
      errors++;
      $display("FAIL %s in=\"%s\" actual=\"%s\" expected=\"%s\" (stream ok %0d/%0d)",
               req, inp, got, exp, dok, cok);
    end
    @(negedge clk); #(Q);
    checks++;  // R13: terminal state after end byte
    if (!(done && !in_ready && !out_valid)) begin
      errors++;
      $display("FAIL R13 in=\"%s\" actual done=%0d in_ready=%0d out_valid=%0d expected 1/0/0",
               inp, done, in_ready, out_valid);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string x, y, op, exp;
    int qs[3] = '{0, 7, 29};
    do_reset();
    @(negedge clk); #(Q);
    checks++;
    if (out_valid || done) begin
      errors++;
      $display("FAIL reset actual out_valid=%0d done=%0d expected 0/0", out_valid, done);
    end

    // Directed cases
    run_test("xyz[]\\9", "xyz[]\\9", "R2", 1'b0);
    run_test("a[12][34]", "[34]12", "R3", 1'b0);
    run_test("b[12][34]", "[12[34]]", "R4", 1'b1);
    run_test("c[7]", "[7][7]", "R5", 1'b0);
    run_test("c[x[y]]z", "[x[y]][x[y]]z", "R14", 1'b1);
    run_test("d[55]z", "z", "R6", 1'b0);
    run_test("i[xy]z", "xyz", "R7", 1'b0);
    run_test("i[c[1]]", "c[1]", "R7", 1'b0);
    run_test("c[1]i[2]", "[1][1]2", "R5", 1'b1);
    run_test("o[1][2]", "[12]", "R8", 1'b0);
    run_test("o[1[2]][3]", "[1[2]3]", "R14", 1'b0);
    run_test("o[1]z", "[1\\z", "R10", 1'b0);
    run_test("cz", "cz", "R11", 1'b0);
    run_test("a[1]z", "a[1]z", "R11", 1'b1);
    run_test("c[xx", "c[xx", "R11", 1'b0);
    run_test("c[x\\y", "c[x\\y", "R12", 1'b0);

    // Single-operand sweeps across the buffer limit
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n <= DEPTH + 2; n++) begin
        op = (k == 0) ? "c" : (k == 1) ? "d" : "i";
        x = rep("x", n);
        if (n + 2 > DEPTH) exp = {op, "[", x, "]"};
        else if (k == 0) exp = {"[", x, "][", x, "]"};
        else if (k == 1) exp = "";
        else exp = x;
        run_test({op, "[", x, "]"}, exp,
                 (n + 2 > DEPTH) ? "R12" : (k == 0) ? "R5" : (k == 1) ? "R6" : "R7",
                 n[0]);
      end
    end

    // Two-operand sweeps
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p <= DEPTH + 2; p++) begin
        for (int j = 0; j < 3; j++) begin
          op = (k == 0) ? "a" : (k == 1) ? "b" : "o";
          x = rep("x", p); y = rep("y", qs[j]);
          if (k == 2) exp = {"[", x, y, "]"};
          else if (p + qs[j] + 4 > DEPTH) exp = {op, "[", x, "][", y, "]"};
          else if (k == 0) exp = {"[", y, "]", x};
          else exp = {"[", x, "[", y, "]]"};
          run_test({op, "[", x, "][", y, "]"}, exp,
                   (k == 2) ? ((p + qs[j] + 4 > DEPTH) ? "R9" : "R8")
                            : ((p + qs[j] + 4 > DEPTH) ? "R11" : (k == 0) ? "R3" : "R4"),
                   p[0] ^ j[0]);
        end
        // R10: compose without second block, both sides of the limit
        run_test({"o[", rep("x", p), "]"}, {"[", rep("x", p), "\\"}, "R10", p[0]);
      end
    end

    // R1: the same stream with and without stalls
    run_test({"c[", rep("x", 20), "]q"}, {"[", rep("x", 20), "][", rep("x", 20), "]q"}, "R1", 1'b1);
    run_test({"c[", rep("x", 20), "]q"}, {"[", rep("x", 20), "][", rep("x", 20), "]q"}, "R1", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule